// File: doc/BRIEF.md
# Receiver Detection Sequencer

This block is the link-layer side of a receiver detection step on one serial lane. It drives the power-state, electrical-idle and detect-request controls of a PIPE-style transceiver, and it reads back the transceiver's completion pulse and receive status. On a start request it moves the transceiver into the low-power detection state (power code 2'b10) and waits for the transceiver to confirm the change. It then raises the detect request while the transmitter stays in electrical idle. It takes the status word on the completion pulse and returns a one-cycle done pulse carrying one of three results: receiver present, receiver absent, or timeout.

The controller has four states. IDLE waits for a start request. PWR_WAIT drives the power code and waits for the confirmation pulse. DET_WAIT drives the detect request and waits for the completion pulse. REPORT issues the done pulse and returns to IDLE. The transitions are:

- IDLE to PWR_WAIT on start when the low-power state has not yet been confirmed.
- IDLE to DET_WAIT on start when the low-power state is already confirmed.
- PWR_WAIT to DET_WAIT on the confirmation pulse.
- PWR_WAIT to REPORT when the wait expires.
- DET_WAIT to REPORT on the completion pulse or when the wait expires.
- REPORT to IDLE always.

A programmable cycle limit bounds every wait. A confirmed low-power state is remembered, so a later detection goes straight to the detect request.

Top module: `rxdet_seq`

## Requirements
- R1: After synchronous active-high reset, the block is in IDLE with tx_detect_out, done_out, busy_out and tx_idle_out low, pd_ctrl_out equal to 2'b00 (full power), and result_out equal to 2'b00 (no result).
- R2: A start_req sampled high in IDLE, with the low-power state not confirmed, sets pd_ctrl_out to 2'b10 and raises tx_idle_out and busy_out in the next cycle. tx_detect_out stays low until the transceiver confirms the power change with a phy_status_in pulse.
- R3: tx_detect_out rises in the cycle right after the phy_status_in pulse that confirms the power change, and never earlier.
- R4: While tx_detect_out is high, tx_idle_out is high and pd_ctrl_out is 2'b10.
- R5: A phy_status_in pulse seen while tx_detect_out is high qualifies rx_status_in. The value 3'b011 gives result 2'b01 (present), and any other value gives result 2'b10 (absent).
- R6: In the cycle after the qualifying pulse, tx_detect_out is low and done_out is high for exactly one cycle with the result on result_out. result_out then holds that value until the next result, and busy_out is low one cycle after done_out.
- R7: rx_status_in is ignored at all times other than the qualifying pulse, including during the power-change confirmation.
- R8: In each wait state, a phy_status_in pulse must arrive within max(timeout_lim,1) cycles of entering that state. Otherwise done_out pulses after exactly that many cycles with result 2'b11 (timeout). A pulse in the last allowed cycle still counts as in time.
- R9: A timeout while waiting for power confirmation returns pd_ctrl_out to 2'b00 at done_out, and the next detection repeats the power change.
- R10: Once the low-power state is confirmed, a later start_req goes straight to the detect request: tx_detect_out is high in the cycle after start, and pd_ctrl_out stays 2'b10 between detections.
- R11: start_req while busy_out is high, and phy_status_in while in IDLE, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to run one detection |
| timeout_lim | input | TMO_W | Cycle limit for each wait state (0 behaves as 1) |
| phy_status_in | input | 1 | Completion pulse from the transceiver |
| rx_status_in | input | 3 | Receive status word from the transceiver |
| pd_ctrl_out | output | 2 | Power-state code to the transceiver |
| tx_idle_out | output | 1 | Transmitter electrical-idle request |
| tx_detect_out | output | 1 | Receiver-detect request |
| done_out | output | 1 | One-cycle pulse when a result is ready |
| result_out | output | 2 | 00 none, 01 present, 10 absent, 11 timeout |
| busy_out | output | 1 | A detection is in progress |

## Verification
A wrong state shows at the pins within one cycle, because every control output is decoded from the state. If the controller skips PWR_WAIT, tx_detect_out rises before any confirmation pulse. If it stays in DET_WAIT too long, the done pulse arrives late or tx_detect_out stays high after the qualifying pulse. A corrupted remembered power state shows up on pd_ctrl_out between detections, and on the next start as a missing or an extra power-change wait. An off-by-one wait counter moves the timeout done pulse by a cycle, or turns an on-time last-cycle pulse into a timeout.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PWR_WAIT = 2'd1,
        ST_DET_WAIT = 2'd2,
        ST_REPORT   = 2'd3
    } rxdet_state_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_PRESENT = 2'b01,
        RES_ABSENT  = 2'b10,
        RES_TIMEOUT = 2'b11
    } rxdet_result_e;

    localparam logic [1:0] PWR_FULL   = 2'b00;
    localparam logic [1:0] PWR_DETECT = 2'b10;
    localparam int unsigned STAT_W    = 3;
    localparam logic [STAT_W-1:0] STAT_RX_FOUND = 3'b011;

endpackage

// File: rtl/rxdet_wait_timer.sv
module rxdet_wait_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             waiting,
    input  logic             ack,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] elapsed;
    logic [EXT_W-1:0] elapsed_next;

    assign elapsed_next = {1'b0, elapsed} + EXT_W'(1);

    // restart on leaving a wait state or on any acknowledge
    always_ff @(posedge clk) begin
        if (rst || !waiting || ack) begin
            elapsed <= '0;
        end else if (!expire) begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end

    // acknowledge in the last allowed cycle takes priority
    assign expire = waiting && !ack && (elapsed_next >= {1'b0, limit});

endmodule

// File: rtl/rxdet_status_eval.sv
module rxdet_status_eval
    import rxdet_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    output rxdet_result_e     verdict
);
    always_comb begin
        if (status == STAT_RX_FOUND) begin
            verdict = RES_PRESENT;
        end else begin
            verdict = RES_ABSENT;
        end
    end

endmodule

// File: rtl/rxdet_ctrl_fsm.sv
module rxdet_ctrl_fsm
    import rxdet_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          phy_ack,
    input  logic          wait_expire,
    input  rxdet_result_e verdict,
    output logic          waiting,
    output logic [1:0]    pd_ctrl,
    output logic          tx_idle,
    output logic          tx_detect,
    output logic          done,
    output logic          busy,
    output rxdet_result_e result
);
    rxdet_state_e state_q, state_d;
    logic         p1_held_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = p1_held_q ? ST_DET_WAIT : ST_PWR_WAIT;
                end
            end
            ST_PWR_WAIT: begin
                if (phy_ack) begin
                    state_d = ST_DET_WAIT;
                end else if (wait_expire) begin
                    state_d = ST_REPORT;
                end
            end
            ST_DET_WAIT: begin
                if (phy_ack || wait_expire) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // remembered power state and captured result
    always_ff @(posedge clk) begin
        if (rst) begin
            p1_held_q <= 1'b0;
            result    <= RES_NONE;
        end else begin
            unique case (state_q)
                ST_PWR_WAIT: begin
                    if (phy_ack) begin
                        p1_held_q <= 1'b1;
                    end else if (wait_expire) begin
                        p1_held_q <= 1'b0;
                        result    <= RES_TIMEOUT;
                    end
                end
                ST_DET_WAIT: begin
                    if (phy_ack) begin
                        result <= verdict;
                    end else if (wait_expire) begin
                        result <= RES_TIMEOUT;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        waiting   = 1'b0;
        tx_idle   = 1'b1;
        tx_detect = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        pd_ctrl   = p1_held_q ? PWR_DETECT : PWR_FULL;
        unique case (state_q)
            ST_IDLE: begin
                tx_idle = 1'b0;
                busy    = 1'b0;
            end
            ST_PWR_WAIT: begin
                waiting = 1'b1;
                pd_ctrl = PWR_DETECT;
            end
            ST_DET_WAIT: begin
                waiting   = 1'b1;
                tx_detect = 1'b1;
                pd_ctrl   = PWR_DETECT;
            end
            ST_REPORT: begin
                done = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq
    import rxdet_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [TMO_W-1:0] timeout_lim,
    input  logic             phy_status_in,
    input  logic [2:0]       rx_status_in,
    output logic [1:0]       pd_ctrl_out,
    output logic             tx_idle_out,
    output logic             tx_detect_out,
    output logic             done_out,
    output logic [1:0]       result_out,
    output logic             busy_out
);
    logic          waiting;
    logic          expire;
    rxdet_result_e verdict;
    rxdet_result_e result;

    rxdet_wait_timer #(.CNT_W(TMO_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .waiting (waiting),
        .ack     (phy_status_in),
        .limit   (timeout_lim),
        .expire  (expire)
    );

    rxdet_status_eval eval_i (
        .status  (rx_status_in),
        .verdict (verdict)
    );

    rxdet_ctrl_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .phy_ack     (phy_status_in),
        .wait_expire (expire),
        .verdict     (verdict),
        .waiting     (waiting),
        .pd_ctrl     (pd_ctrl_out),
        .tx_idle     (tx_idle_out),
        .tx_detect   (tx_detect_out),
        .done        (done_out),
        .busy        (busy_out),
        .result      (result)
    );

    assign result_out = result;

endmodule

// File: rtl/rxdet_seq_chk.sv
module rxdet_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_req,
    input logic       phy_status_in,
    input logic [2:0] rx_status_in,
    input logic [1:0] pd_ctrl_out,
    input logic       tx_idle_out,
    input logic       tx_detect_out,
    input logic       done_out,
    input logic [1:0] result_out,
    input logic       busy_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tx_detect_out && !done_out && !busy_out));

    assert_busy_idle_R2: assert property (@(posedge clk) disable iff (rst)
        busy_out |-> tx_idle_out);

    assert_detect_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_detect_out) |-> ($past(phy_status_in) || $past(start_req)));

    assert_detect_in_low_power_R4: assert property (@(posedge clk) disable iff (rst)
        tx_detect_out |-> (tx_idle_out && pd_ctrl_out == 2'b10));

    assert_present_code_R5: assert property (@(posedge clk) disable iff (rst)
        (done_out && result_out == 2'b01) |-> $past(phy_status_in && rx_status_in == 3'b011));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_out |=> !done_out);

    assert_detect_drop_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_detect_out) |-> done_out);

endmodule

bind rxdet_seq rxdet_seq_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .start_req     (start_req),
    .phy_status_in (phy_status_in),
    .rx_status_in  (rx_status_in),
    .pd_ctrl_out   (pd_ctrl_out),
    .tx_idle_out   (tx_idle_out),
    .tx_detect_out (tx_detect_out),
    .done_out      (done_out),
    .result_out    (result_out),
    .busy_out      (busy_out)
);

// File: tb/rxdet_seq_tb_top.sv
module rxdet_seq_tb_top;
    localparam int unsigned TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_req = 1'b0;
    logic [TMO_W-1:0] timeout_lim = '0;
    logic             phy_status_in = 1'b0;
    logic [2:0]       rx_status_in = 3'b000;
    logic [1:0]       pd_ctrl_out;
    logic             tx_idle_out;
    logic             tx_detect_out;
    logic             done_out;
    logic [1:0]       result_out;
    logic             busy_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit p1_model = 1'b0;

    always #10 clk = ~clk;

    rxdet_seq #(.TMO_W(TMO_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .start_req     (start_req),
        .timeout_lim   (timeout_lim),
        .phy_status_in (phy_status_in),
        .rx_status_in  (rx_status_in),
        .pd_ctrl_out   (pd_ctrl_out),
        .tx_idle_out   (tx_idle_out),
        .tx_detect_out (tx_detect_out),
        .done_out      (done_out),
        .result_out    (result_out),
        .busy_out      (busy_out)
    );

    function automatic logic [1:0] exp_result(input logic [2:0] rx);
        return (rx == 3'b011) ? 2'b01 : 2'b10;
    endfunction

    function automatic int eff_limit(input int lim);
        return (lim == 0) ? 1 : lim;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // one full detection; pdly/ddly are cycles before each pulse
    task automatic run_detect(input int lim, input int pdly, input int ddly,
                              input logic [2:0] rx, input bit poke_start);
        int eff;
        eff = eff_limit(lim);
        timeout_lim = TMO_W'(lim);
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        if (!p1_model) begin
            chk(pd_ctrl_out == 2'b10 && tx_idle_out && busy_out, "R2 enter power wait",
                int'(pd_ctrl_out), 2);
            if (pdly < eff) begin
                for (int i = 0; i < pdly; i++) begin
                    chk(!tx_detect_out && !done_out, "R3 detect before confirm", int'(tx_detect_out), 0);
                    if (poke_start && i == 0) start_req = 1'b1;
                    rx_status_in = 3'b011;
                    tick();
                    start_req = 1'b0;
                end
                chk(!tx_detect_out, "R3 detect before confirm", int'(tx_detect_out), 0);
                phy_status_in = 1'b1;
                rx_status_in  = 3'b011;
                tick();
                phy_status_in = 1'b0;
                rx_status_in  = 3'($urandom);
                p1_model = 1'b1;
                chk(tx_detect_out, "R3 detect after confirm", int'(tx_detect_out), 1);
            end else begin
                for (int i = 0; i < eff - 1; i++) begin
                    tick();
                    chk(!done_out, "R8 no early timeout", int'(done_out), 0);
                end
                tick();
                chk(done_out && result_out == 2'b11, "R8 power timeout result",
                    int'(result_out), 3);
                chk(pd_ctrl_out == 2'b00, "R9 power released on timeout", int'(pd_ctrl_out), 0);
                p1_model = 1'b0;
                tick();
                chk(!busy_out && !done_out, "R6 idle after report", int'(busy_out), 0);
                return;
            end
        end else begin
            chk(tx_detect_out && pd_ctrl_out == 2'b10, "R10 direct detect", int'(tx_detect_out), 1);
        end
        if (ddly < eff) begin
            for (int i = 0; i < ddly; i++) begin
                chk(tx_detect_out && tx_idle_out && pd_ctrl_out == 2'b10, "R4 detect conditions",
                    int'(pd_ctrl_out), 2);
                if (poke_start) start_req = 1'b1;
                rx_status_in = 3'($urandom);
                tick();
                start_req = 1'b0;
            end
            phy_status_in = 1'b1;
            rx_status_in  = rx;
            tick();
            phy_status_in = 1'b0;
            rx_status_in  = ~rx;
            chk(done_out && !tx_detect_out, "R6 done after qualify", int'(done_out), 1);
            chk(result_out == exp_result(rx), "R5 detection result",
                int'(result_out), int'(exp_result(rx)));
            tick();
            chk(!done_out && !busy_out, "R6 single done pulse", int'(done_out), 0);
            chk(result_out == exp_result(rx), "R7 result held", int'(result_out),
                int'(exp_result(rx)));
        end else begin
            for (int i = 0; i < eff - 1; i++) begin
                tick();
                chk(!done_out && tx_detect_out, "R8 no early timeout", int'(done_out), 0);
            end
            tick();
            chk(done_out && result_out == 2'b11, "R8 detect timeout result", int'(result_out), 3);
            chk(pd_ctrl_out == 2'b10, "R10 power kept", int'(pd_ctrl_out), 2);
            tick();
            chk(!busy_out, "R6 idle after report", int'(busy_out), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20251));
        repeat (3) tick();
        chk(!tx_detect_out && !done_out && !busy_out && !tx_idle_out, "R1 reset outputs",
            int'(busy_out), 0);
        chk(pd_ctrl_out == 2'b00 && result_out == 2'b00, "R1 reset codes", int'(pd_ctrl_out), 0);
        rst = 1'b0;
        tick();

        // R11: stray completion pulse in idle
        phy_status_in = 1'b1;
        rx_status_in  = 3'b011;
        tick();
        phy_status_in = 1'b0;
        chk(!busy_out && !done_out && !tx_detect_out && result_out == 2'b00,
            "R11 idle pulse ignored", int'(busy_out), 0);

        // directed: power timeout, limit zero behaves as one
        run_detect(0, 5, 0, 3'b011, 1'b0);
        // directed: power confirm on last allowed cycle, present
        run_detect(4, 3, 3, 3'b011, 1'b0);
        // directed: direct detect, absent, start poked while busy (R11)
        run_detect(5, 0, 2, 3'b111, 1'b1);
        chk(!busy_out, "R11 start while busy ignored", int'(busy_out), 0);
        // directed: detect timeout keeps power
        run_detect(3, 0, 3, 3'b011, 1'b0);
        // directed: reset clears remembered power state
        rst = 1'b1;
        tick();
        rst = 1'b0;
        p1_model = 1'b0;
        chk(pd_ctrl_out == 2'b00, "R1 reset power code", int'(pd_ctrl_out), 0);
        // R9 follow-up: after power timeout next run repeats power change
        run_detect(2, 4, 0, 3'b000, 1'b0);
        run_detect(6, 1, 1, 3'b011, 1'b0);

        for (int n = 0; n < 60; n++) begin
            int lim;
            lim = int'($urandom_range(0, 7));
            run_detect(lim, int'($urandom_range(0, 8)), int'($urandom_range(0, 8)),
                       ($urandom_range(0, 1) == 1) ? 3'b011 : 3'($urandom),
                       ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 9) == 0) begin
                rst = 1'b1;
                tick();
                rst = 1'b0;
                p1_model = 1'b0;
            end
            repeat (int'($urandom_range(0, 2))) tick();
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule